// File: doc/BRIEF.md
# External Memory Bus Interface Controller

This block sits between a processor's internal load/store path and an off-chip memory bus. The internal side offers a single request with an address, a direction and a 32-bit write word. It is accepted through a ready/valid handshake. Completion is reported by a one-cycle response pulse, which carries the read word on reads. On the external side the block drives an address, a wide data bus with the 32-bit word placed in its upper bits, active-low bank chip selects and active-low read and write strobes. It stretches every access with wait states for as long as the external acknowledge stays low.

Bank selects are decoded from the upper address bits, using per-bank base values held in a small set of control registers. They appear one cycle before the strobe, so they serve as an early indication of a bus cycle. A page-crossing flag shows whether the current access lies in a different page from the previous one. The page size is a power of two, set by an exponent register. An active-low three-state input releases the bus at once and parks any access in flight. After release the access resumes and finishes only once acknowledge is seen high.

The state machine has six states. IDLE waits for a request. ADDR drives the address and selects. STROBE asserts the strobe. WAIT holds the strobe while acknowledge is low. SUSPEND parks the access while the bus is floated. DONE issues the response. The transitions are:
- IDLE goes to ADDR when a request arrives and the bus is not floated.
- ADDR goes to STROBE, or to SUSPEND if the three-state input is low.
- STROBE and WAIT go to DONE when acknowledge is high, to WAIT when it is low, and to SUSPEND when the three-state input is low.
- SUSPEND goes to WAIT once the three-state input is released.
- DONE always returns to IDLE.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset all bank selects and both strobes are high (inactive), the response pulse is low and the internal side is ready.
- R2: In the cycle after a request is accepted, the address and the decoded bank select are driven while both strobes are still high. With the reset bank bases (bank 0 from upper nibble 0, bank 1 from upper nibble 8), an address whose top four bits are below 8 drives selects 2'b10, and any other address drives 2'b01.
- R3: A read drives the read strobe low from the second cycle after acceptance. With acknowledge high it completes one cycle later with a response pulse carrying data-bus bits [47:16].
- R4: A write drives the write strobe low and enables the data drivers. The data bus carries the write word in bits [47:16] and zero in bits [15:0].
- R5: While acknowledge is low, the strobe stays low, the address is held and no response is given. The response follows in the cycle after acknowledge is sampled high.
- R6: The page flag is high during an access whose address, shifted right by (8 + page exponent), differs from the previous access's address shifted by the same amount.
- R7: While the three-state input is low, the bus and data output enables are low, no request is accepted and no access completes.
- R8: After the three-state input is released, a suspended access drives its strobe again. It completes only in the cycle after acknowledge is sampled high, and it then returns the correct read word.
- R9: Control register index 0 holds the page exponent in bits [2:0]. Index 1+k holds the base nibble of bank k. A write to any other index has no effect on the decode.
- R10: The read and write strobes are never low together, and each response pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_sel | input | CFG_AW | Control register index |
| cfg_wdata | input | CFG_DW | Control register write value |
| req_valid | input | 1 | Internal request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | WORD_W | Request write word |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read word, valid with rsp_valid on reads |
| mem_addr | output | ADDR_W | External address |
| mem_wdata | output | DATA_W | External write data |
| mem_rdata | input | DATA_W | External read data |
| mem_data_oe | output | 1 | Data bus driver enable |
| mem_bus_oe | output | 1 | Address, select and strobe driver enable |
| mem_sel_n | output | NBANK | Active-low bank selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_ack | input | 1 | External acknowledge, low adds wait states |
| mem_ts_n | input | 1 | Active-low three-state request |
| mem_page | output | 1 | Page-crossing flag |

## Verification
The hardest situation to reach is a read parked in SUSPEND and then resumed. To get there, the three-state input must fall while the read strobe is already low. Acknowledge must then be held low across the release, so that the bench can see the strobe come back without completing. The bench drops the three-state input and acknowledge in the strobe cycle of a read. It then releases the three-state input with acknowledge still low for two cycles before raising it, and checks that no response appears until the cycle after acknowledge goes high.

// File: rtl/mebc_pkg.sv
package mebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STROBE,
        ST_WAIT,
        ST_SUSPEND,
        ST_DONE
    } mebc_state_e;
endpackage

// File: rtl/mebc_cfg_regs.sv
module mebc_cfg_regs #(
    parameter int NBANK  = 2,
    parameter int BND_W  = 4,
    parameter int CFG_AW = 2,
    parameter int CFG_DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_sel,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    output logic [2:0]             page_exp,
    output logic [NBANK*BND_W-1:0] bank_base
);
    localparam int STEP = (1 << BND_W) / NBANK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            page_exp <= 3'd0;
        else if (cfg_we && cfg_sel == CFG_AW'(0))
            page_exp <= cfg_wdata[2:0];
    end

    for (genvar k = 0; k < NBANK; k++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_base[k*BND_W +: BND_W] <= BND_W'(k * STEP);
            else if (cfg_we && cfg_sel == CFG_AW'(k + 1))
                bank_base[k*BND_W +: BND_W] <= cfg_wdata[BND_W-1:0];
        end
    end
endmodule

// File: rtl/mebc_bank_dec.sv
module mebc_bank_dec #(
    parameter int ADDR_W = 24,
    parameter int NBANK  = 2,
    parameter int BND_W  = 4
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NBANK*BND_W-1:0] bank_base,
    input  logic                   enable,
    output logic [NBANK-1:0]       sel_n
);
    logic [BND_W-1:0] hi;
    assign hi = addr[ADDR_W-1 -: BND_W];

    for (genvar k = 0; k < NBANK; k++) begin : g_sel
        logic lo_ok, up_ok;
        assign lo_ok = hi >= bank_base[k*BND_W +: BND_W];
        if (k == NBANK - 1) begin : g_top
            assign up_ok = 1'b1;
        end else begin : g_mid
            assign up_ok = hi < bank_base[(k+1)*BND_W +: BND_W];
        end
        assign sel_n[k] = !(enable && lo_ok && up_ok);
    end
endmodule

// File: rtl/mebc_page_cmp.sv
module mebc_page_cmp #(
    parameter int ADDR_W   = 24,
    parameter int PAGE_MIN = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic [2:0]        page_exp,
    output logic              crossed
);
    logic [5:0] shamt;
    assign shamt   = 6'(PAGE_MIN) + {3'd0, page_exp};
    assign crossed = (cur_addr >> shamt) != (prev_addr >> shamt);
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import mebc_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 48,
    parameter int WORD_W   = 32,
    parameter int WORD_LSB = 16,
    parameter int NBANK    = 2,
    parameter int BND_W    = 4,
    parameter int PAGE_MIN = 8,
    parameter int CFG_DW   = 8,
    localparam int CFG_AW  = $clog2(NBANK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_sel,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_data_oe,
    output logic              mem_bus_oe,
    output logic [NBANK-1:0]  mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    input  logic              mem_ack,
    input  logic              mem_ts_n,
    output logic              mem_page
);
    localparam int LOW_W = WORD_LSB;

    mebc_state_e           state, state_nx;
    logic [ADDR_W-1:0]     cur_q, prev_q;
    logic [WORD_W-1:0]     wd_q, rd_q;
    logic                  wr_q;
    logic [2:0]            page_exp;
    logic [NBANK*BND_W-1:0] bank_base;
    logic                  in_access, strobe_on, crossed, take, finish;

    mebc_cfg_regs #(.NBANK(NBANK), .BND_W(BND_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .page_exp(page_exp), .bank_base(bank_base)
    );

    mebc_bank_dec #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BND_W(BND_W)) u_dec (
        .addr(cur_q), .bank_base(bank_base), .enable(in_access), .sel_n(mem_sel_n)
    );

    mebc_page_cmp #(.ADDR_W(ADDR_W), .PAGE_MIN(PAGE_MIN)) u_page (
        .cur_addr(cur_q), .prev_addr(prev_q), .page_exp(page_exp), .crossed(crossed)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid && mem_ts_n) state_nx = ST_ADDR;
            ST_ADDR:    state_nx = mem_ts_n ? ST_STROBE : ST_SUSPEND;
            ST_STROBE,
            ST_WAIT:    begin
                if (!mem_ts_n)    state_nx = ST_SUSPEND;
                else if (mem_ack) state_nx = ST_DONE;
                else              state_nx = ST_WAIT;
            end
            ST_SUSPEND: if (mem_ts_n) state_nx = ST_WAIT;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    assign take   = (state == ST_IDLE) && req_valid && mem_ts_n;
    assign finish = ((state == ST_STROBE) || (state == ST_WAIT)) && mem_ts_n && mem_ack;

    // state and access registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_q  <= '0;
            prev_q <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
            rd_q   <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                prev_q <= cur_q;
                cur_q  <= req_addr;
                wd_q   <= req_wdata;
                wr_q   <= req_write;
            end
            if (finish && !wr_q)
                rd_q <= mem_rdata[WORD_LSB +: WORD_W];
        end
    end

    // outputs
    always_comb begin
        in_access   = (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_WAIT);
        strobe_on   = (state == ST_STROBE) || (state == ST_WAIT);
        mem_rd_n    = !(strobe_on && !wr_q);
        mem_wr_n    = !(strobe_on && wr_q);
        mem_bus_oe  = mem_ts_n && (state != ST_SUSPEND);
        mem_data_oe = mem_bus_oe && wr_q && in_access;
        mem_addr    = cur_q;
        mem_wdata   = {wd_q, {LOW_W{1'b0}}};
        mem_page    = in_access && crossed;
        req_ready   = (state == ST_IDLE) && mem_ts_n;
        rsp_valid   = (state == ST_DONE);
        rsp_rdata   = rd_q;
    end
endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk #(
    parameter int ADDR_W = 24,
    parameter int NBANK  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_bus_oe,
    input logic              mem_data_oe,
    input logic [NBANK-1:0]  mem_sel_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              mem_ack,
    input logic              mem_ts_n
);
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ts_n |-> (!mem_bus_oe && !mem_data_oe));

    p_no_finish_floated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ts_n |=> !rsp_valid);

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !mem_ack && mem_ts_n) |=> ($stable(mem_addr) && !rsp_valid));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_sel_n && mem_rd_n && mem_wr_n));
endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_bus_oe(mem_bus_oe), .mem_data_oe(mem_data_oe),
    .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_ack(mem_ack), .mem_ts_n(mem_ts_n)
);

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [23:0] mem_addr;
    logic [47:0] mem_wdata;
    logic [47:0] mem_rdata = '0;
    logic        mem_data_oe, mem_bus_oe, mem_rd_n, mem_wr_n, mem_page;
    logic [1:0]  mem_sel_n;
    logic        mem_ack = 1'b1, mem_ts_n = 1'b1;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_ctrl i_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_data_oe(mem_data_oe), .mem_bus_oe(mem_bus_oe), .mem_sel_n(mem_sel_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_ack(mem_ack), .mem_ts_n(mem_ts_n),
        .mem_page(mem_page)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // issue a request; returns at the negedge where the block is in its address cycle
    task automatic start(input logic w, input logic [23:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] idx, input logic [7:0] v);
        cfg_we = 1'b1; cfg_sel = idx; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // plain read with acknowledge high, checking selects and page flag in the address cycle
    task automatic read_chk(input string req, input logic [23:0] a, input logic [1:0] sel, input logic pg);
        mem_ack = 1'b1;
        start(1'b0, a, 32'h0);
        chk(req, "sel_n", 64'(mem_sel_n), 64'(sel));
        chk(req, "page", 64'(mem_page), 64'(pg));
        @(negedge clk);
        @(negedge clk);
        chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "sel_n", 64'(mem_sel_n), 64'h3);
        chk("R1", "rd_n", 64'(mem_rd_n), 64'd1);
        chk("R1", "wr_n", 64'(mem_wr_n), 64'd1);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
    endtask

    task automatic t_read;
        mem_ack = 1'b1;
        mem_rdata = {32'hA5A5_1234, 16'hBEEF};
        start(1'b0, 24'h12_3456, 32'h0);
        chk("R2", "sel_n early", 64'(mem_sel_n), 64'h2);
        chk("R2", "rd_n early", 64'(mem_rd_n), 64'd1);
        chk("R2", "addr", 64'(mem_addr), 64'h12_3456);
        @(negedge clk);
        chk("R3", "rd_n", 64'(mem_rd_n), 64'd0);
        chk("R10", "wr_n during read", 64'(mem_wr_n), 64'd1);
        @(negedge clk);
        chk("R3", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk("R3", "rdata", 64'(rsp_rdata), 64'hA5A5_1234);
        chk("R3", "rd_n released", 64'(mem_rd_n), 64'd1);
        @(negedge clk);
        chk("R10", "pulse one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_write;
        mem_ack = 1'b1;
        start(1'b1, 24'h9A_0010, 32'hDEAD_BEEF);
        chk("R2", "bank1 sel", 64'(mem_sel_n), 64'h1);
        @(negedge clk);
        chk("R4", "wr_n", 64'(mem_wr_n), 64'd0);
        chk("R10", "rd_n during write", 64'(mem_rd_n), 64'd1);
        chk("R4", "data", 64'(mem_wdata), 64'hDEAD_BEEF_0000);
        chk("R4", "data_oe", 64'(mem_data_oe), 64'd1);
        @(negedge clk);
        chk("R4", "rsp_valid", 64'(rsp_valid), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_wait;
        mem_ack = 1'b0;
        mem_rdata = {32'h0BAD_F00D, 16'h1111};
        start(1'b0, 24'h00_0100, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R5", "rd_n held", 64'(mem_rd_n), 64'd0);
            chk("R5", "addr held", 64'(mem_addr), 64'h00_0100);
            chk("R5", "no rsp", 64'(rsp_valid), 64'd0);
            @(negedge clk);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        chk("R5", "rsp after ack", 64'(rsp_valid), 64'd1);
        chk("R5", "rdata", 64'(rsp_rdata), 64'h0BAD_F00D);
        @(negedge clk);
    endtask

    task automatic t_page;
        read_chk("R6", 24'h00_01F0, 2'h2, 1'b0);
        read_chk("R6", 24'h00_0200, 2'h2, 1'b1);
        cfg_write(2'd0, 8'd1);
        read_chk("R9", 24'h00_0300, 2'h2, 1'b0);
        read_chk("R6", 24'h00_0400, 2'h2, 1'b1);
    endtask

    task automatic t_suspend;
        mem_ack = 1'b1;
        mem_rdata = {32'hCAFE_0042, 16'h0000};
        start(1'b0, 24'h00_0410, 32'h0);
        @(negedge clk);
        chk("R8", "strobe before float", 64'(mem_rd_n), 64'd0);
        mem_ts_n = 1'b0; mem_ack = 1'b0;
        #1;
        chk("R7", "bus_oe floated", 64'(mem_bus_oe), 64'd0);
        @(negedge clk);
        chk("R7", "no rsp floated", 64'(rsp_valid), 64'd0);
        mem_ack = 1'b1;
        @(negedge clk);
        chk("R7", "no rsp floated ack", 64'(rsp_valid), 64'd0);
        chk("R7", "data_oe floated", 64'(mem_data_oe), 64'd0);
        mem_ts_n = 1'b1; mem_ack = 1'b0;
        @(negedge clk);
        chk("R8", "bus_oe back", 64'(mem_bus_oe), 64'd1);
        chk("R8", "strobe resumed", 64'(mem_rd_n), 64'd0);
        chk("R8", "no rsp without ack", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk("R8", "still waiting", 64'(rsp_valid), 64'd0);
        mem_ack = 1'b1;
        @(negedge clk);
        chk("R8", "rsp after ack", 64'(rsp_valid), 64'd1);
        chk("R8", "rdata", 64'(rsp_rdata), 64'hCAFE_0042);
        @(negedge clk);
    endtask

    task automatic t_float_idle;
        mem_ts_n = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00_0420;
        #1;
        chk("R7", "not ready floated", 64'(req_ready), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R7", "no access started", 64'(mem_rd_n), 64'd1);
        req_valid = 1'b0;
        mem_ts_n = 1'b1;
        #1;
        chk("R7", "idle after float", 64'(req_ready), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_config;
        cfg_write(2'd2, 8'h04);
        read_chk("R9", 24'h50_0000, 2'h1, 1'b1);
        cfg_write(2'd3, 8'h0F);
        read_chk("R9", 24'h30_0000, 2'h2, 1'b1);
        read_chk("R9", 24'h40_0000, 2'h1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_wait();
        t_page();
        t_suspend();
        t_float_idle();
        t_config();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule